// File: doc/BRIEF.md
# Serial Even Parity Generator and Checker

This block adds and verifies even parity on characters that travel bit-serially between a character holding register and a recirculating serial memory. Each character occupies a frame of `FRAME_BITS` bit times. The seven data bits come first, least significant first. The parity bit follows at a fixed bit time, `PAR_SLOT`. Two marker bits close the frame.

On the write side, a toggle flip-flop follows the keyboard character as it leaves the holding register. At the parity bit time, the block injects a 1 if the data has an odd number of ones, so the stored character is always even. In recirculation frames, the generator is kept silent.

On the read side, a second toggle follows each character coming out of memory, counting data bits and the parity bit. At the parallel-copy point, the last bit time of the frame, the block latches a substitute flag. The display then draws a solid block in place of the character whenever that count was odd. The flag holds for the whole following character period.

Top module: `serial_parity_gc`

## Requirements
- R1: After reset, `blank` is 0, the frame position is bit time 1, and no parity bit is injected.
- R2: In a keyboard frame (`kbd_frame`=1) whose seven data bits (bit times 1..7 on `wr_bit`) hold an even number of ones, `wr_serial` is 0 at bit time 8.
- R3: In a keyboard frame whose data bits hold an odd number of ones, `par_inject` and `wr_serial` are 1 at bit time 8, so the ones in bit times 1..8 of `wr_serial` are even.
- R4: `par_inject` is never 1 at any bit time other than 8.
- R5: In a recirculation frame (`kbd_frame`=0), `wr_serial` and `par_inject` stay 0 for the whole frame.
- R6: In a keyboard frame, `wr_serial` equals `wr_bit` at bit times 1..7 and is 0 at bit times 9 and 10.
- R7: After the bit-time-10 strobe, `blank` is 1 when `rd_bit` over bit times 1..8 of that frame carried an odd number of ones, and 0 when the count was even.
- R8: `blank` changes only on the bit-time-10 strobe and holds its value throughout the next frame.
- R9: `frame_sync` with `bit_en` marks bit time 1. It restarts the bit numbering and clears both parity toggles, so bits from an earlier, partial frame have no effect.
- R10: `rd_bit` values at bit times 9 and 10 have no effect on `blank`.
- R11: Cycles with `bit_en`=0 advance nothing: the bit position and both toggles hold their values, and `wr_serial` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| frame_sync | input | 1 | With `bit_en`, marks bit time 1 of a frame |
| kbd_frame | input | 1 | Current frame carries a keyboard character |
| wr_bit | input | 1 | Serial data bit from holding-register output stage |
| rd_bit | input | 1 | Serial data bit leaving the memory |
| wr_serial | output | 1 | Serial bit to memory input: data plus generated parity |
| par_inject | output | 1 | Corrective parity 1 being inserted this bit time |
| blank | output | 1 | Substitute-block flag for the character now held |

## Verification
On every cycle, the embedded assertions check several properties. Injection happens only at the parity bit time. A recirculation frame keeps the write output silent. The flag changes only at the copy strobe. The bit position never leaves its range, and it holds when no strobe arrives. The even-ones outcome itself can only be seen across a whole frame. So the bench's character scenarios must show it: even and odd data, all-zero and all-one characters, mixed recirculation and keyboard frames, marker bits that must be ignored, strobe gaps, a cut-short frame followed by a resync, and reset in the middle of a run.

// File: rtl/serial_parity_gc.sv
module serial_parity_gc #(
  parameter int FRAME_BITS = 10,
  parameter int PAR_SLOT   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic frame_sync,
  input  logic kbd_frame,
  input  logic wr_bit,
  input  logic rd_bit,
  output logic wr_serial,
  output logic par_inject,
  output logic blank
);
  localparam int SW = $clog2(FRAME_BITS + 1);
  localparam logic [SW-1:0] FIRST = SW'(1);
  localparam logic [SW-1:0] PSLOT = SW'(PAR_SLOT);
  localparam logic [SW-1:0] LAST  = SW'(FRAME_BITS);

  logic [SW-1:0] slot_q, cur;
  logic gen_odd, chk_odd, blank_q;
  logic data_slot, copy_pt;

  assign cur       = frame_sync ? FIRST : slot_q;
  assign data_slot = cur < PSLOT;
  assign copy_pt   = bit_en && (cur == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= FIRST;
    else if (bit_en) slot_q <= (cur == LAST) ? FIRST : cur + FIRST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gen_odd <= 1'b0;
    else if (bit_en) begin
      if (cur == FIRST) gen_odd <= wr_bit;
      else if (data_slot) gen_odd <= gen_odd ^ wr_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chk_odd <= 1'b0;
    else if (bit_en) begin
      if (cur == FIRST) chk_odd <= rd_bit;
      else if (cur <= PSLOT) chk_odd <= chk_odd ^ rd_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) blank_q <= 1'b0;
    else if (copy_pt) blank_q <= chk_odd;
  end

  assign par_inject = bit_en && kbd_frame && (cur == PSLOT) && gen_odd;
  assign wr_serial  = (bit_en && kbd_frame && data_slot && wr_bit) || par_inject;
  assign blank      = blank_q;

  AST_INJECT_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    par_inject |-> (slot_q == PSLOT || (frame_sync && PSLOT == FIRST))); // R4
  AST_RECIRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !kbd_frame |-> (!wr_serial && !par_inject)); // R5
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && kbd_frame && cur == PSLOT) |-> (wr_serial == gen_odd)); // R3
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_pt |=> $stable(blank)); // R8
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(slot_q) && $stable(gen_odd) && $stable(chk_odd))); // R11
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q >= FIRST && slot_q <= LAST)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !wr_serial); // R11
endmodule

// File: tb/serial_parity_gc_tb_top.sv
module serial_parity_gc_tb_top;
  logic clk = 1'b0;
  logic rst_n, bit_en, frame_sync, kbd_frame, wr_bit, rd_bit;
  logic wr_serial, par_inject, blank;
  int n_chk = 0, n_bad = 0;
  logic exp_blank_prev;

  always #4 clk = ~clk;

  serial_parity_gc dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
    .kbd_frame(kbd_frame), .wr_bit(wr_bit), .rd_bit(rd_bit),
    .wr_serial(wr_serial), .par_inject(par_inject), .blank(blank));

  // {kbd, wr[6:0], rd[7:0] (slots 1..8), tail[1:0] (slots 10,9), exp_inject, exp_blank}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 7'b0000000, 8'b00000000, 2'b11, 1'b0, 1'b0},
    {1'b1, 7'b0000001, 8'b00000001, 2'b00, 1'b1, 1'b1},
    {1'b1, 7'b1010101, 8'b11010101, 2'b10, 1'b0, 1'b1},
    {1'b1, 7'b1111111, 8'b11111111, 2'b01, 1'b1, 1'b0},
    {1'b0, 7'b0110001, 8'b10110001, 2'b00, 1'b0, 1'b0},
    {1'b0, 7'b1000000, 8'b01000000, 2'b11, 1'b0, 1'b1},
    {1'b1, 7'b0011100, 8'b10011100, 2'b10, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic kbd, input logic [6:0] wr, input logic [7:0] rd,
                           input logic [1:0] tail, input logic e_inj, input logic e_blank,
                           input int gap);
    logic [9:0] ws, pi, exp_ws;
    ws = '0; pi = '0;
    exp_ws = {2'b00, e_inj, (kbd ? wr : 7'b0)};
    for (int s = 1; s <= 10; s++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        bit_en = 1'b0; frame_sync = 1'b0; wr_bit = 1'b1; rd_bit = 1'b1;
        #1 check(wr_serial == 1'b0, "R11 idle quiet", wr_serial, 0);
      end
      @(negedge clk);
      bit_en = 1'b1; frame_sync = (s == 1); kbd_frame = kbd;
      wr_bit = (s <= 7) ? wr[s-1] : 1'b0;
      rd_bit = (s <= 8) ? rd[s-1] : tail[s-9];
      #1;
      ws[s-1] = wr_serial; pi[s-1] = par_inject;
      if (s == 5) check(blank == exp_blank_prev, "R8 hold", blank, exp_blank_prev);
    end
    @(negedge clk);
    bit_en = 1'b0; frame_sync = 1'b0; wr_bit = 1'b0; rd_bit = 1'b0;
    #1;
    check(ws == exp_ws, "R2/R3/R5/R6 stream", ws, exp_ws);
    check(pi == {2'b00, e_inj, 7'b0}, "R4 inject slot", pi, {2'b00, e_inj, 7'b0});
    check(blank == e_blank, "R7/R10 blank", blank, e_blank);
    exp_blank_prev = e_blank;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; frame_sync = 1'b0; kbd_frame = 1'b1;
    wr_bit = 1'b0; rd_bit = 1'b0; exp_blank_prev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(blank == 1'b0, "R1 reset blank", blank, 0);
    check(par_inject == 1'b0, "R1 reset inject", par_inject, 0);

    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][19], VEC[i][18:12], VEC[i][11:4], VEC[i][3:2], VEC[i][1], VEC[i][0], 0);

    // R11: strobe gaps between bit times
    run_frame(1'b1, 7'b0100110, 8'b00000111, 2'b00, 1'b1, 1'b1, 2);

    // R9: a short frame with ones, then resync
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      bit_en = 1'b1; frame_sync = (s == 0); kbd_frame = 1'b1; wr_bit = 1'b1; rd_bit = 1'b1;
    end
    run_frame(1'b1, 7'b0000011, 8'b00000011, 2'b11, 1'b0, 1'b0, 0);

    // R10: marker bits alone odd
    run_frame(1'b1, 7'b0000000, 8'b00000000, 2'b01, 1'b0, 1'b0, 0);

    // R1: reset clears a set flag
    run_frame(1'b1, 7'b0000001, 8'b00010000, 2'b00, 1'b1, 1'b1, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1 check(blank == 1'b0, "R1 reset mid-run", blank, 0);
    exp_blank_prev = 1'b0;
    run_frame(1'b0, 7'b1111111, 8'b10000000, 2'b00, 1'b0, 1'b1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule